// File: doc/BRIEF.md
# Framing Bit Error Injector

This block sits in the transmit data path of a T1 line and inverts selected framing bits so that test equipment or the far end sees framing errors on demand. Each clock carries one serial bit. An external strobe marks the cycles that carry a framing bit, and a second pulse, given together with the strobe, marks the framing bit of the first frame of a multiframe. From these two inputs the block tracks which framing bits qualify for corruption: the terminal framing bits in D4 mode and the framing pattern sequence bits in ESF mode. Every bit leaves the block one clock after it arrives.

Two independent controls choose the bits to corrupt. A level control, while it is held high, inverts one qualifying bit in every `PERIOD` (default 128). It gives a steady, low error rate that does not break synchronization. A burst control acts on its rising edge only. The edge inverts the next `BURST_LEN` (default 3) consecutive qualifying bits, which is enough to drive the remote receiver out of frame alignment. When both controls pick the same bit, that bit is inverted once. Frame generation, line coding and register access live outside the block.

Top module: `fbi_injector`

## Requirements
- R1: While `rst_n` is low, `tx_out` is 0.
- R2: A bit presented in a cycle with `fbit_stb` low appears unchanged on `tx_out` one clock later.
- R3: In D4 mode (`esf_sel` = 0), a framing bit qualifies when its position in the multiframe is even (0, 2, 4 …). Position 0 is the strobed bit with `mf_sync` high, and each later strobed bit adds 1. Framing bits at odd positions are never inverted.
- R4: In ESF mode (`esf_sel` = 1), a framing bit qualifies only when its position modulo 4 equals 3. All other framing bits pass unchanged.
- R5: While `per_en` is high, every `PERIOD`-th qualifying bit is inverted on `tx_out`. The first inverted bit is the `PERIOD`-th qualifying bit seen with `per_en` high.
- R6: A cycle with `per_en` low clears the periodic count. No periodic inversion occurs while `per_en` is low, and after it is raised again a further `PERIOD` qualifying bits pass before the next inversion.
- R7: A cycle in which `burst_req` is high after a cycle in which it was low (or after reset) is a rising edge. The next `BURST_LEN` qualifying bits in later cycles are inverted. A qualifying bit in the cycle of the edge itself is not counted.
- R8: Holding `burst_req` high after its burst has finished produces no further inversions.
- R9: A new rising edge of `burst_req` during an active burst restarts the count, so `BURST_LEN` more qualifying bits are inverted after the new edge.
- R10: A bit selected by both the periodic and the burst mechanisms is inverted exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in | input | 1 | Serial transmit bit entering the block |
| fbit_stb | input | 1 | High in cycles that carry a framing bit |
| mf_sync | input | 1 | With `fbit_stb`, marks position 0 of the multiframe |
| esf_sel | input | 1 | Framing mode: 0 = D4, 1 = ESF |
| per_en | input | 1 | Level control for periodic corruption |
| burst_req | input | 1 | Rising edge starts a corruption burst |
| tx_out | output | 1 | Serial transmit bit, one clock later, possibly inverted |

## Verification
The bench builds the block with `PERIOD` = 16 and `BURST_LEN` = 3. With these values the periodic counter wraps several times within a short run, in D4 mode and in ESF mode. The shorter period also lets the bench place a burst so that its last bit lands on the same qualifying bit as a periodic inversion, which covers the single-inversion rule. A burst edge is also raised again one cycle after a dropout in the middle of a burst, and the burst control is held high long after its burst ends.

// File: rtl/fbi_pkg.sv
package fbi_pkg;

  typedef enum logic {
    FMODE_D4  = 1'b0,
    FMODE_ESF = 1'b1
  } fmode_e;

  localparam int unsigned PHASE_W = 2;

  // A framing bit position qualifies for corruption in the given mode
  function automatic logic pos_qualifies(fmode_e mode, logic [PHASE_W-1:0] pos);
    logic q;
    if (mode == FMODE_ESF) q = (pos == 2'd3);
    else                   q = (pos[0] == 1'b0);
    return q;
  endfunction

endpackage

// File: rtl/fbi_fbit_phase.sv
module fbi_fbit_phase
  import fbi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   fbit_stb,
  input  logic   mf_sync,
  input  fmode_e mode,
  output logic   qual
);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_d;
  logic [PHASE_W-1:0] cur_pos;
  logic               phase_en;

  always_comb begin
    cur_pos  = mf_sync ? '0 : phase_q;
    phase_en = fbit_stb;
    phase_d  = cur_pos + 1'b1;
    qual     = fbit_stb && pos_qualifies(mode, cur_pos);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  p_sync_pos_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fbit_stb && mf_sync) |=> (phase_q == PHASE_W'(1)));

  p_phase_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_stb |=> $stable(phase_q));

endmodule

// File: rtl/fbi_periodic.sv
module fbi_periodic #(
  parameter int unsigned PERIOD = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic qual,
  output logic hit
);

  localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    hit    = en && qual && (cnt_q == LAST);
    cnt_en = !en || qual;
    if (!en)      cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  p_clear_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  p_hit_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (en && qual));

  p_wrap_after_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));

endmodule

// File: rtl/fbi_burst.sv
module fbi_burst #(
  parameter int unsigned BURST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic qual,
  output logic hit
);

  localparam int unsigned REM_W = $clog2(BURST_LEN + 1);
  localparam logic [REM_W-1:0] FULL = REM_W'(BURST_LEN);

  logic             req_q;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_d;
  logic             rise;
  logic             rem_en;

  always_comb begin
    rise   = req && !req_q;
    hit    = qual && !rise && (rem_q != '0);
    rem_en = rise || hit;
    rem_d  = rise ? FULL : (rem_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  p_load_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !req_q) |=> (rem_q == FULL));

  p_idle_no_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !hit);

  p_rem_bounded_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q <= FULL);

endmodule

// File: rtl/fbi_injector.sv
module fbi_injector
  import fbi_pkg::*;
#(
  parameter int unsigned PERIOD    = 128,
  parameter int unsigned BURST_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_in,
  input  logic fbit_stb,
  input  logic mf_sync,
  input  logic esf_sel,
  input  logic per_en,
  input  logic burst_req,
  output logic tx_out
);

  logic   qual;
  logic   hit_per;
  logic   hit_bst;
  logic   flip;
  logic   out_d;
  logic   out_q;
  fmode_e mode;

  assign mode = fmode_e'(esf_sel);

  fbi_fbit_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .fbit_stb (fbit_stb),
    .mf_sync  (mf_sync),
    .mode     (mode),
    .qual     (qual)
  );

  fbi_periodic #(.PERIOD(PERIOD)) u_periodic (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (per_en),
    .qual  (qual),
    .hit   (hit_per)
  );

  fbi_burst #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (burst_req),
    .qual  (qual),
    .hit   (hit_bst)
  );

  always_comb begin
    flip  = hit_per || hit_bst;
    out_d = tx_in ^ flip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign tx_out = out_q;

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |-> !tx_out);

  p_pass_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fbit_stb |=> (tx_out == $past(tx_in)));

  p_unqualified_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (tx_out == $past(tx_in)));

  p_single_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_per && hit_bst) |=> (tx_out == !$past(tx_in)));

endmodule

// File: tb/fbi_injector_tb.sv
module fbi_injector_tb;

  localparam int unsigned PERIOD    = 16;
  localparam int unsigned BURST_LEN = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_in, fbit_stb, mf_sync, esf_sel, per_en, burst_req;
  logic tx_out;

  always #2.5 clk = ~clk;

  fbi_injector #(.PERIOD(PERIOD), .BURST_LEN(BURST_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_in(tx_in), .fbit_stb(fbit_stb),
    .mf_sync(mf_sync), .esf_sel(esf_sel), .per_en(per_en),
    .burst_req(burst_req), .tx_out(tx_out)
  );

  typedef struct {
    logic  val;
    string tag;
  } item_t;

  item_t exp_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // independent reference state
  int unsigned m_pos, m_pcnt, m_rem, m_fbcount, m_cyc;
  bit m_bq;

  task automatic step(input bit d, input bit stb, input bit sync,
                      input bit esf, input bit per, input bit brq, input string scen);
    item_t it;
    int unsigned cur;
    bit qual, ph, bh, rise;
    @(negedge clk);
    tx_in = d; fbit_stb = stb; mf_sync = sync;
    esf_sel = esf; per_en = per; burst_req = brq;
    cur  = sync ? 0 : m_pos;
    qual = stb && (esf ? (cur == 3) : (cur % 2 == 0));
    if (stb) m_pos = (cur + 1) % 4;
    ph = per && qual && (m_pcnt == PERIOD - 1);
    if (!per) m_pcnt = 0;
    else if (qual) m_pcnt = ph ? 0 : m_pcnt + 1;
    rise = brq && !m_bq;
    bh   = qual && !rise && (m_rem != 0);
    if (rise) m_rem = BURST_LEN;
    else if (bh) m_rem = m_rem - 1;
    m_bq = brq;
    it.val = d ^ (ph | bh);
    if (ph && bh)   it.tag = {scen, "/R10"};
    else if (ph)    it.tag = {scen, "/R5"};
    else if (bh)    it.tag = {scen, "/R7"};
    else if (stb)   it.tag = {scen, esf ? "/R4" : "/R3"};
    else            it.tag = {scen, "/R2"};
    exp_q.push_back(it);
  endtask

  // one frame-paced cycle: strobe every 4th cycle, multiframe sync on framing bit 0
  task automatic tick(input bit esf, input bit per, input bit brq, input string scen);
    bit stb, sync;
    int unsigned mf;
    mf   = esf ? 24 : 12;
    stb  = (m_cyc % 4 == 0);
    sync = stb && (m_fbcount % mf == 0);
    step(1'($urandom_range(0, 1)), stb, sync, esf, per, brq, scen);
    if (stb) m_fbcount++;
    m_cyc++;
  endtask

  task automatic run(input int n, input bit esf, input bit per, input bit brq, input string scen);
    for (int i = 0; i < n; i++) tick(esf, per, brq, scen);
  endtask

  // monitor: compares each registered output against the scoreboard
  always @(posedge clk) begin
    #1;
    if (rst_n && exp_q.size() > 0) begin
      item_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (tx_out !== e.val) begin
        n_fail++;
        $display("FAIL %s: tx_out=%b expected=%b at %0t", e.tag, tx_out, e.val, $time);
      end
    end
  end

  initial begin
    #900000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_pos = 0; m_pcnt = 0; m_rem = 0; m_bq = 0; m_fbcount = 0; m_cyc = 0;
    rst_n = 1'b0;
    tx_in = 1'b1; fbit_stb = 1'b1; mf_sync = 1'b0;
    esf_sel = 1'b0; per_en = 1'b1; burst_req = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    n_chk++;
    if (tx_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: tx_out=%b expected=0 during reset", tx_out);
    end
    @(negedge clk);
    per_en = 1'b0; fbit_stb = 1'b0; tx_in = 1'b0;
    rst_n = 1'b1;

    // R2/R3: plain D4 traffic, no corruption
    run(200, 0, 0, 0, "R2");
    // R5: periodic in D4
    run(4 * 2 * PERIOD * 3, 0, 1, 0, "R5");
    // R6: drop and restore periodic control mid-count
    run(4 * 2 * (PERIOD / 2), 0, 1, 0, "R6");
    run(20, 0, 0, 0, "R6");
    run(4 * 2 * PERIOD * 2, 0, 1, 0, "R6");
    run(40, 0, 0, 0, "R6");
    // R7/R8: burst edge, then hold high long after
    run(1, 0, 0, 1, "R7");
    run(200, 0, 0, 1, "R8");
    run(10, 0, 0, 0, "R8");
    // R9: restart during an active burst
    run(9, 0, 0, 1, "R9");
    run(1, 0, 0, 0, "R9");
    run(120, 0, 0, 1, "R9");
    run(10, 0, 0, 0, "R9");
    // R4: ESF mode with periodic then burst
    run(4 * 4 * PERIOD * 2, 1, 1, 0, "R4");
    run(2, 1, 0, 0, "R4");
    run(200, 1, 0, 1, "R4");
    run(10, 1, 0, 0, "R4");
    // R10: align a burst so its last bit meets a periodic inversion
    run(4, 0, 1, 0, "R10");
    while (m_pcnt != PERIOD - 3) tick(0, 1, 0, "R10");
    run(200, 0, 1, 1, "R10");
    run(20, 0, 0, 0, "R10");

    @(posedge clk);
    @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule